// File: doc/BRIEF.md
# Two-Level Priority Interrupt Gate

This block collects interrupt events from three external pins and turns them into two request lines toward a processor: a high-priority request and a low-priority request. Each pin is brought into the clock domain through a synchronizer. An edge of the chosen polarity on a pin sets a sticky event flag, and software clears that flag by writing a one to it. A control register holds the global gates, a priority-mode switch and one edge-polarity bit per pin. A source register holds a per-pin enable bit and a per-pin priority class.

With priority mode off, every enabled source drives the high request, and only the main gate controls it. With priority mode on, each source goes to the high or the low line according to its class. The low line needs both the main gate and the low gate. Clearing the main gate silences both lines. Both request outputs are registered.

Software reaches the registers through a plain single-cycle bus. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. No register access has side effects on a read.

Top module: `irq_gate`

## Requirements
- R1: Address 0 is the control register. Bit 7 is the main gate, bit 6 the low gate, bit 5 the priority mode, and bits 2, 1 and 0 select the edge polarity of pins 2, 1 and 0. After reset it reads 0x07. Address 1 (source register) and address 2 (flag register) read 0x00 after reset, and both outputs are low.
- R2: Control bits 4 and 3, source bits 7 and 3, flag bits 7..3 and the whole of address 3 read as 0, and writes to them have no effect.
- R3: While bit 5 is 0, control bit 6 reads as 0 and has no effect on either request.
- R4: A polarity bit of 1 selects the rising edge of its pin and 0 selects the falling edge. A matching edge sets flag bit i at address 2. With the default two-stage synchronizer, the flag is visible after the third rising clock edge following the pin change, and a resulting request after the fourth.
- R5: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If an edge sets a flag in the same cycle that a write clears it, the flag stays set.
- R6: In the source register, bits 2..0 enable pins 2..0 and bits 6..4 give their class (1 = high, 0 = low). A flag with its enable at 0 raises no request, yet it still sets and reads back.
- R7: With bit 5 at 0, every enabled set flag drives `irq_hi` whenever bit 7 is 1, regardless of its class, and `irq_lo` stays 0.
- R8: With bit 5 at 1, enabled flags of high class drive `irq_hi` when bit 7 is 1. Enabled flags of low class drive `irq_lo` only when bits 7 and 6 are both 1.
- R9: With bit 7 at 0, neither request is raised, in either mode.
- R10: Changing a polarity bit while the pin is steady sets no flag.
- R11: A request stays high in the cycle of the write that clears its last qualifying flag or its gate, and is low after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 3 | External interrupt pins, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_hi | output | 1 | Registered high-priority request |
| irq_lo | output | 1 | Registered low-priority request |

## Verification
The checker assumes that the register bus holds known values once reset is released. It also assumes that flag bits fall only through a write strobe aimed at address 2, so the sticky-flag property treats any other cause of a drop as a fault. The bench drives the bus and the pins only at falling clock edges. It holds each pin level for several cycles, far longer than the synchronizer depth, so every deliberate pin change is seen as exactly one edge. It always clears stray flags left by idle-level changes before it measures a case.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int N_PINS = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_SRC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd2;

  // control register bit positions
  localparam int CTRL_GEN_HI = 7;
  localparam int CTRL_GEN_LO = 6;
  localparam int CTRL_PRIO   = 5;

  // source register: enables at bit 0 upward, classes at this offset
  localparam int SRC_CLS_LSB = 4;

  typedef struct packed {
    logic gen_hi;
    logic gen_lo;
    logic prio_mode;
  } gate_ctl_t;

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect
  import irq_gate_pkg::*;
#(
  parameter int N           = N_PINS,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_async,
  input  logic [N-1:0] edge_pol,
  input  logic [N-1:0] flag_clr,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   flag_q;
    logic                   level;
    logic                   hit;

    assign level = sync_q[SYNC_STAGES-1];

    // edge found by comparing two synchronized samples; polarity only picks
    // which direction counts, so a polarity change alone cannot make a hit
    always_comb begin
      if (edge_pol[i]) hit = level & ~prev_q;
      else             hit = ~level & prev_q;
    end

    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async[i]};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_async[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        prev_q <= level;
        // a new event outranks a simultaneous clear
        flag_q <= hit | (flag_q & ~flag_clr[i]);
      end
    end

    assign flags[i] = flag_q;
  end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_gate_pkg::*;
#(
  parameter int N = N_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [N-1:0]      flags,
  output logic [REG_W-1:0]  rdata,
  output gate_ctl_t         gate,
  output logic [N-1:0]      edge_pol,
  output logic [N-1:0]      src_en,
  output logic [N-1:0]      src_hi,
  output logic [N-1:0]      flag_clr
);

  gate_ctl_t    gate_q;
  logic [N-1:0] pol_q;
  logic [N-1:0] en_q;
  logic [N-1:0] cls_q;

  logic wr_ctrl, wr_src, wr_flag;

  assign wr_ctrl = wr && (addr == ADR_CTRL);
  assign wr_src  = wr && (addr == ADR_SRC);
  assign wr_flag = wr && (addr == ADR_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      pol_q  <= '1;
    end else if (wr_ctrl) begin
      gate_q.gen_hi    <= wdata[CTRL_GEN_HI];
      gate_q.gen_lo    <= wdata[CTRL_GEN_LO];
      gate_q.prio_mode <= wdata[CTRL_PRIO];
      pol_q            <= wdata[N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cls_q <= '0;
    end else if (wr_src) begin
      en_q  <= wdata[N-1:0];
      cls_q <= wdata[SRC_CLS_LSB +: N];
    end
  end

  assign flag_clr = wr_flag ? wdata[N-1:0] : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL: begin
        rdata[CTRL_GEN_HI] = gate_q.gen_hi;
        rdata[CTRL_GEN_LO] = gate_q.gen_lo & gate_q.prio_mode;
        rdata[CTRL_PRIO]   = gate_q.prio_mode;
        rdata[N-1:0]       = pol_q;
      end
      ADR_SRC: begin
        rdata[N-1:0]            = en_q;
        rdata[SRC_CLS_LSB +: N] = cls_q;
      end
      ADR_FLAG: rdata[N-1:0] = flags;
      default:  rdata = '0;
    endcase
  end

  assign gate     = gate_q;
  assign edge_pol = pol_q;
  assign src_en   = en_q;
  assign src_hi   = cls_q;

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
  import irq_gate_pkg::*;
#(
  parameter int N = N_PINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] src_en,
  input  logic [N-1:0] src_hi,
  input  gate_ctl_t    gate,
  output logic         irq_hi,
  output logic         irq_lo
);

  logic [N-1:0] live;
  logic [N-1:0] hi_class;
  logic         hi_any, lo_any;
  logic         hi_d, lo_d;

  always_comb begin
    live     = flags & src_en;
    // without priority mode every source counts as high class
    hi_class = gate.prio_mode ? src_hi : '1;
    hi_any   = |(live & hi_class);
    lo_any   = |(live & ~hi_class);
    hi_d     = gate.gen_hi & hi_any;
    lo_d     = gate.gen_hi & gate.gen_lo & gate.prio_mode & lo_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_hi <= 1'b0;
      irq_lo <= 1'b0;
    end else begin
      irq_hi <= hi_d;
      irq_lo <= lo_d;
    end
  end

endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int NUM_PINS    = N_PINS,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] ext_pin,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                irq_hi,
  output logic                irq_lo
);

  gate_ctl_t           gate_w;
  logic [NUM_PINS-1:0] pol_w;
  logic [NUM_PINS-1:0] en_w;
  logic [NUM_PINS-1:0] cls_w;
  logic [NUM_PINS-1:0] clr_w;
  logic [NUM_PINS-1:0] flags_w;

  irq_ctrl_regs #(.N(NUM_PINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .flags    (flags_w),
    .rdata    (reg_rdata),
    .gate     (gate_w),
    .edge_pol (pol_w),
    .src_en   (en_w),
    .src_hi   (cls_w),
    .flag_clr (clr_w)
  );

  irq_pin_detect #(.N(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ext_pin),
    .edge_pol  (pol_w),
    .flag_clr  (clr_w),
    .flags     (flags_w)
  );

  irq_req_gen #(.N(NUM_PINS)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .flags  (flags_w),
    .src_en (en_w),
    .src_hi (cls_w),
    .gate   (gate_w),
    .irq_hi (irq_hi),
    .irq_lo (irq_lo)
  );

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk
  import irq_gate_pkg::*;
#(
  parameter int N = N_PINS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              irq_hi,
  input logic              irq_lo,
  input logic [N-1:0]      flags,
  input gate_ctl_t         gate
);

  localparam logic [REG_W-1:0] CTRL_IMPL = 8'hE0 | REG_W'((1 << N) - 1);

  // R8
  lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> $past(gate.gen_hi && gate.gen_lo && gate.prio_mode));

  // R9
  main_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi || irq_lo) |-> $past(gate.gen_hi));

  // R6
  hi_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> ($past(flags) != '0));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && (reg_addr == ADR_FLAG)) |-> ((flags & $past(flags)) == $past(flags)));

  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_CTRL) |-> ((reg_rdata & ~CTRL_IMPL) == '0));

  // R3
  lo_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == ADR_CTRL) && !gate.prio_mode) |-> !reg_rdata[CTRL_GEN_LO]);

  // R7
  no_lo_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gate.prio_mode) |-> !irq_lo);

endmodule

bind irq_gate irq_gate_chk #(.N(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq_hi    (irq_hi),
  .irq_lo    (irq_lo),
  .flags     (flags_w),
  .gate      (gate_w)
);

// File: tb/irq_gate_test.sv
`timescale 1ns/1ps
module irq_gate_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ext_pin = 3'b000;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_hi, irq_lo;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_gate uut (
    .clk (clk), .rst_n (rst_n), .ext_pin (ext_pin),
    .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .irq_hi (irq_hi), .irq_lo (irq_lo)
  );

  localparam logic [1:0] A_CTRL = 2'd0, A_SRC = 2'd1, A_FLAG = 2'd2;

  // {ctrl, src, fire mask, expected hi, expected lo}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {8'h87, 8'h07, 3'b001, 1'b1, 1'b0},  // flat mode, class ignored
    {8'h07, 8'h07, 3'b111, 1'b0, 1'b0},  // main gate off
    {8'hA7, 8'h07, 3'b010, 1'b0, 1'b0},  // low class, low gate off
    {8'hE7, 8'h07, 3'b010, 1'b0, 1'b1},  // low class, both gates
    {8'hE0, 8'h17, 3'b001, 1'b1, 1'b0},  // falling edge, high class
    {8'hE2, 8'h57, 3'b110, 1'b1, 1'b1},  // mixed polarity and class
    {8'hE7, 8'h75, 3'b010, 1'b0, 1'b0},  // source disabled
    {8'hC7, 8'h07, 3'b100, 1'b1, 1'b0},  // low gate set, flat mode
    {8'hA7, 8'h77, 3'b100, 1'b1, 1'b0},  // high class needs no low gate
    {8'h87, 8'h00, 3'b111, 1'b0, 1'b0}   // all disabled
  };

  function automatic logic [7:0] ctrl_view(input logic [7:0] v);
    logic [7:0] r;
    r = v & 8'hE7;
    if (!v[5]) r[6] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(A_CTRL, rd); chk("R1 ctrl reset", rd, 8'h07);
    bus_rd(A_SRC, rd);  chk("R1 src reset", rd, 8'h00);
    bus_rd(A_FLAG, rd); chk("R1 flag reset", rd, 8'h00);
    chk("R1 outputs reset", {6'b0, irq_hi, irq_lo}, 8'h00);

    // R2 unimplemented bits
    bus_wr(A_CTRL, 8'hFF); bus_rd(A_CTRL, rd); chk("R2 ctrl unused bits", rd, 8'hE7);
    bus_wr(A_SRC, 8'hFF);  bus_rd(A_SRC, rd);  chk("R2 src unused bits", rd, 8'h77);
    bus_wr(2'd3, 8'hFF);   bus_rd(2'd3, rd);   chk("R2 address 3", rd, 8'h00);
    bus_wr(A_FLAG, 8'hFF); bus_rd(A_FLAG, rd); chk("R2 flag unused bits", rd, 8'h00);

    // R3 low gate hidden in flat mode
    bus_wr(A_CTRL, 8'hDF); bus_rd(A_CTRL, rd); chk("R3 low gate hidden", rd, 8'h87);

    // vector table: R4 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      logic [7:0] c, s;
      logic [2:0] m;
      logic       eh, el;
      {c, s, m, eh, el} = VEC[k];
      bus_wr(A_CTRL, c);
      bus_wr(A_SRC, s);
      @(negedge clk); ext_pin = ~c[2:0];
      repeat (6) @(negedge clk);
      bus_wr(A_FLAG, 8'h07);
      repeat (2) @(negedge clk);
      ext_pin = ~c[2:0] ^ m;
      repeat (6) @(negedge clk);
      chk($sformatf("R7/R8/R9 irq_hi vec %0d", k), {7'b0, irq_hi}, {7'b0, eh});
      chk($sformatf("R7/R8/R9 irq_lo vec %0d", k), {7'b0, irq_lo}, {7'b0, el});
      bus_rd(A_FLAG, rd); chk($sformatf("R4/R6 flags vec %0d", k), rd, {5'b0, m});
      bus_rd(A_CTRL, rd); chk($sformatf("R1/R3 ctrl view vec %0d", k), rd, ctrl_view(c));
    end

    // R10 polarity change alone
    bus_wr(A_CTRL, 8'h87); bus_wr(A_SRC, 8'h07);
    @(negedge clk); ext_pin = 3'b000;
    repeat (6) @(negedge clk);
    bus_wr(A_FLAG, 8'h07);
    repeat (2) @(negedge clk);
    bus_wr(A_CTRL, 8'h80);
    repeat (5) @(negedge clk);
    bus_rd(A_FLAG, rd); chk("R10 no flag on polarity change", rd, 8'h00);
    chk("R10 no request", {7'b0, irq_hi}, 8'h00);

    // R4 latency and R11 drop after clear
    bus_wr(A_CTRL, 8'h87);
    @(negedge clk); ext_pin[0] = 1'b1;
    repeat (2) @(negedge clk);
    bus_rd(A_FLAG, rd); chk("R4 flag not yet after two edges", rd, 8'h00);
    @(negedge clk);
    bus_rd(A_FLAG, rd); chk("R4 flag after third edge", rd, 8'h01);
    chk("R4 request not yet", {7'b0, irq_hi}, 8'h00);
    @(negedge clk);
    chk("R4 request after fourth edge", {7'b0, irq_hi}, 8'h01);
    reg_wr = 1'b1; reg_addr = A_FLAG; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R11 request held in clear cycle", {7'b0, irq_hi}, 8'h01);
    @(negedge clk);
    chk("R11 request low after clear", {7'b0, irq_hi}, 8'h00);

    // R11 gate clear drop, with pin 1 event
    @(negedge clk); ext_pin[1] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 request from pin 1", {7'b0, irq_hi}, 8'h01);
    reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 8'h07;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R11 held in gate-clear cycle", {7'b0, irq_hi}, 8'h01);
    @(negedge clk);
    chk("R9 low after main gate cleared", {7'b0, irq_hi}, 8'h00);

    // R5 partial write-one-to-clear
    ext_pin[2] = 1'b1;
    repeat (5) @(negedge clk);
    bus_rd(A_FLAG, rd); chk("R5 two flags set", rd, 8'h06);
    bus_wr(A_FLAG, 8'h04);
    bus_rd(A_FLAG, rd); chk("R5 only written bit cleared", rd, 8'h02);

    // R5 set outranks simultaneous clear (pin 0 falling)
    bus_wr(A_CTRL, 8'h86);
    @(negedge clk); ext_pin[0] = 1'b0;
    repeat (2) @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_FLAG; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0;
    bus_rd(A_FLAG, rd); chk("R5 set wins over clear", rd & 8'h01, 8'h01);

    finish_run();
  end

endmodule